// File: doc/BRIEF.md
# Bank-Interleaved Low-Power Word Memory

This block is a single-port synchronous word memory built from several equal banks. The banks are interleaved on the low bits of the word address. Only one bank is enabled for any access, and the others see neither a chip enable nor a write enable. This limits switching to one half-size array per cycle instead of one full-size array. The default build has two banks. The in-bank word address is the upper part of the address, and it is routed to every bank.

When an access is presented, the bank-select bits are captured in a register on the same clock edge that launches the bank read. That register picks which bank's output register drives the read-data port on the following cycle. A write also loads the written word into the selected bank's output register, so the read port always shows the word at the last accessed address. Each bank has a cycle counter that advances whenever that bank is enabled. The counters let an observer confirm that every access touched exactly one bank.

The full-size configuration uses `ADDR_W = 15` and `DATA_W = 32`, which gives two banks of 16K words. The default parameters build a smaller 2K-word instance (`ADDR_W = 11`) that has the same structure.

Top module: `lpm_split_mem`

## Requirements
- R1: The memory holds 2**ADDR_W independent words of DATA_W bits. Address 0 and address 2**ADDR_W-1 both store and return their own data.
- R2: Address bit 0 selects the bank: an even address enables bank 0 and an odd address enables bank 1. The selected bank's counter rises by one for each access.
- R3: Each valid access enables exactly one bank. The counter of the unselected bank does not change.
- R4: A write asserts a write enable only on the selected bank. Writing an even address leaves the word at the adjacent odd address unchanged, and the reverse also holds.
- R5: While acc_valid is low, no bank is enabled, nothing is written even with wr_en high, and both counters hold their values.
- R6: While acc_valid is low, rdata holds its previous value, whatever addr, wr_en and wdata do.
- R7: Read data has one cycle of latency. rdata does not change before the clock edge that takes the access, and it shows the result after that edge.
- R8: After a write, rdata shows the written word. A later read of that address returns the written word, in whichever bank it lives.
- R9: While rst_n is low, rdata reads 0 and both counters read 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is requested this cycle |
| wr_en | input | 1 | The access is a write (1) or a read (0) |
| addr | input | ADDR_W | Word address; bit 0 picks the bank |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after the access |
| bank_hits | output | 2*CNT_W | Per-bank enable counters; bank 0 in the low CNT_W bits |

## Verification
Directed cases write adjacent even and odd addresses with different words and read both back. This separates correct interleaving from a select bit that is swapped or ignored. Idle cycles with wr_en high and changing address and data test that an idle cycle neither writes nor disturbs the read port. The extreme addresses 0 and the top address test the in-bank address slice. A constrained random mix of reads, writes and idle cycles, biased toward a small address window, then compares every access against a bench model of the contents and of both counters. This exposes latency errors, write-through errors and cross-bank enables.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  // Number of low address bits used to interleave the banks.
  localparam int SEL_W     = 1;
  localparam int NUM_BANKS = 1 << SEL_W;
endpackage

// File: rtl/lpm_bank_decode.sv
module lpm_bank_decode #(
  parameter int ADDR_W = 11
) (
  input  logic                                   acc_valid,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      addr,
  output logic [lpm_pkg::NUM_BANKS-1:0]          bank_en,
  output logic [lpm_pkg::NUM_BANKS-1:0]          bank_we,
  output logic [ADDR_W-lpm_pkg::SEL_W-1:0]       bank_addr,
  output logic [lpm_pkg::SEL_W-1:0]              bank_sel
);
  import lpm_pkg::*;

  assign bank_sel  = addr[SEL_W-1:0];
  assign bank_addr = addr[ADDR_W-1:SEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    always_comb begin
      bank_en[b] = acc_valid && (bank_sel == SEL_W'(b));
      bank_we[b] = bank_en[b] && wr_en;
    end
  end
endmodule

// File: rtl/lpm_bank_ram.sv
module lpm_bank_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dout_nxt;

  // Storage: no reset, written only when this bank is selected.
  always_ff @(posedge clk) begin
    if (en && we) mem[a] <= wd;
  end

  // Output register: read data, or write-through of the written word.
  always_comb begin
    dout_nxt = dout;
    if (en) dout_nxt = we ? wd : mem[a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= dout_nxt;
  end

  // R6: an unselected bank keeps its output register.
  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
  // R8: a write shows the written word on the bank output.
  p_write_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |=> dout == $past(wd));
endmodule

// File: rtl/lpm_read_steer.sv
module lpm_read_steer #(
  parameter int DW = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     capture,
  input  logic [lpm_pkg::SEL_W-1:0]                sel_in,
  input  logic [lpm_pkg::NUM_BANKS-1:0][DW-1:0]    bank_dout,
  output logic [DW-1:0]                            rdata
);
  import lpm_pkg::*;

  logic [SEL_W-1:0] sel_q, sel_nxt;

  always_comb begin
    sel_nxt = sel_q;
    if (capture) sel_nxt = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_nxt;
  end

  assign rdata = bank_dout[sel_q];

  // R7: the select captured at the access edge steers the next cycle.
  p_sel_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> sel_q == $past(sel_in));
  // R6: the select is held while idle.
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(sel_q));
endmodule

// File: rtl/lpm_access_counter.sv
module lpm_access_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (inc) cnt_nxt = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R2: one step per enabled cycle.
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> cnt == $past(cnt) + W'(1));
  // R5: no change without an enable.
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/lpm_split_mem.sv
module lpm_split_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   acc_valid,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [DATA_W-1:0]                      wdata,
  output logic [DATA_W-1:0]                      rdata,
  output logic [lpm_pkg::NUM_BANKS*CNT_W-1:0]    bank_hits
);
  import lpm_pkg::*;

  localparam int BANK_AW = ADDR_W - SEL_W;

  logic [NUM_BANKS-1:0]             bank_en;
  logic [NUM_BANKS-1:0]             bank_we;
  logic [BANK_AW-1:0]               bank_addr;
  logic [SEL_W-1:0]                 bank_sel;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_dout;

  lpm_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_valid (acc_valid),
    .wr_en     (wr_en),
    .addr      (addr),
    .bank_en   (bank_en),
    .bank_we   (bank_we),
    .bank_addr (bank_addr),
    .bank_sel  (bank_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lpm_bank_ram #(.AW(BANK_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[b]),
      .we    (bank_we[b]),
      .a     (bank_addr),
      .wd    (wdata),
      .dout  (bank_dout[b])
    );

    lpm_access_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (bank_en[b]),
      .cnt   (bank_hits[b*CNT_W +: CNT_W])
    );
  end

  lpm_read_steer #(.DW(DATA_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (acc_valid),
    .sel_in    (bank_sel),
    .bank_dout (bank_dout),
    .rdata     (rdata)
  );

  // R2: the bank named by the low address bits is the one enabled.
  p_sel_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> bank_en[addr[SEL_W-1:0]]);
  // R3: exactly one bank per access.
  p_one_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones(bank_en) == 1);
  // R4: a write enable never reaches an unselected bank.
  p_we_only_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we & ~bank_en) == '0);
  // R5: no bank enabled when idle.
  p_idle_no_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> bank_en == '0);
  // R6: the read port holds across an idle cycle.
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(rdata));
endmodule

// File: tb/lpm_split_mem_test.sv
module lpm_split_mem_test;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              acc_valid;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [2*CNT_W-1:0] bank_hits;

  int n_checks;
  int n_fails;
  bit finished;

  logic [DATA_W-1:0] model [DEPTH];
  bit                written [DEPTH];
  logic [CNT_W-1:0]  exp_cnt [2];

  lpm_split_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .bank_hits (bank_hits)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] hits(input int b);
    return bank_hits[b*CNT_W +: CNT_W];
  endfunction

  // One cycle of stimulus, driven at the falling edge and checked at the next one.
  task automatic do_op(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] prev;
    int b;
    prev = rdata;
    acc_valid = v; wr_en = w; addr = a; wdata = d;
    #1;
    chk("R7 before edge", 64'(rdata), 64'(prev));
    @(posedge clk);
    @(negedge clk);
    b = int'(a[0]);
    if (v) begin
      exp_cnt[b] = exp_cnt[b] + CNT_W'(1);
      if (w) begin
        model[a] = d;
        written[a] = 1'b1;
      end
      if (written[a]) chk(w ? "R8 write-through" : "R8 readback", 64'(rdata), 64'(model[a]));
      chk("R2 selected counter", 64'(hits(b)), 64'(exp_cnt[b]));
      chk("R3 other counter", 64'(hits(1 - b)), 64'(exp_cnt[1 - b]));
    end else begin
      chk("R6 idle hold", 64'(rdata), 64'(prev));
      chk("R5 idle counters", 64'({hits(1), hits(0)}), 64'({exp_cnt[1], exp_cnt[0]}));
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; finished = 1'b0;
    exp_cnt[0] = '0; exp_cnt[1] = '0;
    for (int i = 0; i < DEPTH; i++) written[i] = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R9 reset rdata", 64'(rdata), 64'd0);
    chk("R9 reset counters", 64'(bank_hits), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: adjacent even/odd words live in different banks.
    do_op(1, 1, 11'd10, 32'hAAAA_0010);
    do_op(1, 1, 11'd11, 32'h5555_0011);
    do_op(1, 0, 11'd10, '0);
    chk("R4 even word kept", 64'(rdata), 64'h0000_0000_AAAA_0010);
    do_op(1, 0, 11'd11, '0);
    chk("R4 odd word kept", 64'(rdata), 64'h0000_0000_5555_0011);

    // R5/R6: idle cycles with a write pending change nothing.
    do_op(0, 1, 11'd10, 32'hDEAD_BEEF);
    do_op(0, 1, 11'd11, 32'hFEED_F00D);
    do_op(1, 0, 11'd10, '0);
    chk("R5 no idle write", 64'(rdata), 64'h0000_0000_AAAA_0010);

    // R1: address extremes.
    do_op(1, 1, 11'd0, 32'h0123_4567);
    do_op(1, 1, 11'(DEPTH - 1), 32'h89AB_CDEF);
    do_op(1, 0, 11'd0, '0);
    chk("R1 low address", 64'(rdata), 64'h0000_0000_0123_4567);
    do_op(1, 0, 11'(DEPTH - 1), '0);
    chk("R1 top address", 64'(rdata), 64'h0000_0000_89AB_CDEF);

    // Constrained random mix.
    for (int k = 0; k < 4000; k++) begin
      bit v, w;
      logic [ADDR_W-1:0] a;
      v = ($urandom % 5) != 0;
      w = ($urandom % 2) == 0;
      a = (($urandom % 2) == 0) ? ADDR_W'($urandom % 64) : ADDR_W'($urandom % DEPTH);
      do_op(v, w, a, $urandom);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule